// File: doc/BRIEF.md
# Table-Driven Dual-Port State Machine

This block builds a finite state machine whose next-state and output logic sit in a read-only lookup table instead of in gates. The table address joins the current state code, in the upper bits, with the condition inputs, in the lower bits. Each stored word holds the next state code in its upper field and the output bits in its lower field. The table has a synchronous read, so its read register is the state register: the state field of that register feeds straight back into the next address, and the output field drives the outputs directly.

The table is filled once, at elaboration, by a constant function and is never written while running. Two read ports share this one table. Each port is a machine of its own, with its own clock, reset and condition inputs. Sizes come from parameters: `ST_BITS` state bits, `CND_BITS` condition bits and `OUT_BITS` output bits. The table has 2^(ST_BITS+CND_BITS) words of ST_BITS+OUT_BITS bits.

The built-in table is a modulo counter with a clear input. With the defaults, state codes 0 to 5 are legal. Codes 6 and 7 have table entries that lead back to code 0. Condition bit 1 is *clear* and bit 0 is *step*. Output bit 0 is the *top* flag, bit 1 is the *at-zero* flag and bit 2 is the *stepped* flag.

Top module: `rom_fsm_dual`

## Requirements
- R1: While a port's reset is high at a rising edge of its clock, that port's state becomes 0 and its outputs become `RST_OUT` (default 3'b100), whatever its condition inputs are.
- R2: When condition bit 1 (clear) is 1 at an edge, the state after that edge is 0, output bit 1 is 1 and output bit 2 is 0.
- R3: When the condition is 2'b01 (step), the state after the edge is the old state plus one. From the highest legal code (5) it wraps to 0. The state never leaves the legal range 0..5.
- R4: When the condition is 2'b00, the state after the edge equals the state before it.
- R5: Output bit 0 is 1 exactly when the state just registered is the highest legal code (5). It is 0 during reset.
- R6: Output bit 2 is 1 exactly when the last edge applied a step. Output bit 1 is 1 exactly when the state just registered is 0.
- R7: Condition inputs are sampled on the same edge that registers the table read, so state and outputs reflect a condition change exactly one cycle later.
- R8: The two ports are independent. Resetting or driving port B has no effect on the state or outputs of port A, and the reverse is also true, even when the two clocks are unrelated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Clock of machine A |
| rst_a | input | 1 | Synchronous active-high reset of machine A |
| cond_a | input | CND_BITS | Condition inputs of machine A (bit 0 step, bit 1 clear) |
| state_a | output | ST_BITS | Registered state code of machine A |
| out_a | output | OUT_BITS | Registered outputs of machine A |
| clk_b | input | 1 | Clock of machine B |
| rst_b | input | 1 | Synchronous active-high reset of machine B |
| cond_b | input | CND_BITS | Condition inputs of machine B |
| state_b | output | ST_BITS | Registered state code of machine B |
| out_b | output | OUT_BITS | Registered outputs of machine B |

## Verification
Each machine's state lives only in its table read register. A wrong table word, a wrong address field order or a wrong feedback slice therefore shows up as a wrong `state` or `out` value one clock after the faulty condition was applied. That first wrong value also corrupts the next address, so the error persists in the following cycles. The bench compares both ports on every cycle of their own clocks against a behavioural counter model, so a fault appears within one cycle of the first stimulus that reaches it. A port that disturbs the other one shows up during the cycles when only the other port is held in reset.

// File: rtl/rom_fsm_pkg.sv
package rom_fsm_pkg;

  // Table word for one {state, condition} address of the demonstration
  // machine: a modulo counter over the legal codes with step and clear.
  // Codes at or above the legal count recover to code 0.
  function automatic int unsigned demo_word(int unsigned st, int unsigned cnd,
                                            int unsigned st_bits, int unsigned out_bits);
    int unsigned legal;
    int unsigned nxt;
    int unsigned o;
    bit          clr;
    bit          stp;
    legal = (32'd1 << st_bits) - 32'd2;
    clr   = ((cnd >> 1) & 32'd1) != 0;
    stp   = ((cnd & 32'd1) != 0) && !clr && (st < legal);
    if (st >= legal)  nxt = 0;
    else if (clr)     nxt = 0;
    else if (stp)     nxt = (st == legal - 1) ? 0 : st + 1;
    else              nxt = st;
    o = 0;
    if (stp)               o = o | 32'd4;
    if (nxt == 0)          o = o | 32'd2;
    if (nxt == legal - 1)  o = o | 32'd1;
    return (nxt << out_bits) | o;
  endfunction

endpackage

// File: rtl/rom_fsm_table.sv
module rom_fsm_table #(
  parameter int ST_BITS  = 3,
  parameter int CND_BITS = 2,
  parameter int OUT_BITS = 3,
  parameter int NPORTS   = 2,
  parameter int AW       = ST_BITS + CND_BITS,
  parameter int DW       = ST_BITS + OUT_BITS,
  parameter logic [DW-1:0] RST_WORD = '0
) (
  input  logic [NPORTS-1:0]         clk,
  input  logic [NPORTS-1:0]         rst,
  input  logic [NPORTS-1:0][AW-1:0] addr,
  output logic [NPORTS-1:0][DW-1:0] rdata
);

  localparam int DEPTH    = 1 << AW;
  localparam int CND_MASK = (1 << CND_BITS) - 1;

  logic [DW-1:0] rom [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      rom[i] = DW'(rom_fsm_pkg::demo_word(int'(i) >> CND_BITS, int'(i) & CND_MASK,
                                          ST_BITS, OUT_BITS));
    end
  end

  // One synchronous read port per machine; the read register is the state.
  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic [DW-1:0] q;
    always_ff @(posedge clk[p]) begin
      if (rst[p]) q <= RST_WORD;
      else        q <= rom[addr[p]];
    end
    assign rdata[p] = q;
  end

endmodule

// File: rtl/rom_fsm_lane.sv
module rom_fsm_lane #(
  parameter int ST_BITS  = 3,
  parameter int CND_BITS = 2,
  parameter int OUT_BITS = 3
) (
  input  logic [CND_BITS-1:0]         cond,
  input  logic [ST_BITS+OUT_BITS-1:0] word,
  output logic [ST_BITS+CND_BITS-1:0] addr,
  output logic [ST_BITS-1:0]          state,
  output logic [OUT_BITS-1:0]         outs
);

  // Upper field of the word is the state; it is fed back as the upper address.
  assign state = word[ST_BITS+OUT_BITS-1:OUT_BITS];
  assign outs  = word[OUT_BITS-1:0];
  assign addr  = {state, cond};

endmodule

// File: rtl/rom_fsm_dual.sv
module rom_fsm_dual #(
  parameter int ST_BITS  = 3,
  parameter int CND_BITS = 2,
  parameter int OUT_BITS = 3,
  parameter logic [OUT_BITS-1:0] RST_OUT = 3'b100
) (
  input  logic                clk_a,
  input  logic                rst_a,
  input  logic [CND_BITS-1:0] cond_a,
  output logic [ST_BITS-1:0]  state_a,
  output logic [OUT_BITS-1:0] out_a,
  input  logic                clk_b,
  input  logic                rst_b,
  input  logic [CND_BITS-1:0] cond_b,
  output logic [ST_BITS-1:0]  state_b,
  output logic [OUT_BITS-1:0] out_b
);

  localparam int NP = 2;
  localparam int AW = ST_BITS + CND_BITS;
  localparam int DW = ST_BITS + OUT_BITS;
  localparam logic [DW-1:0] RST_WORD = {{ST_BITS{1'b0}}, RST_OUT};

  logic [NP-1:0]               clk_v;
  logic [NP-1:0]               rst_v;
  logic [NP-1:0][CND_BITS-1:0] cond_v;
  logic [NP-1:0][AW-1:0]       addr_v;
  logic [NP-1:0][DW-1:0]       word_v;
  logic [NP-1:0][ST_BITS-1:0]  st_v;
  logic [NP-1:0][OUT_BITS-1:0] out_v;

  assign clk_v  = {clk_b, clk_a};
  assign rst_v  = {rst_b, rst_a};
  assign cond_v = {cond_b, cond_a};

  for (genvar p = 0; p < NP; p++) begin : g_lane
    rom_fsm_lane #(
      .ST_BITS (ST_BITS),
      .CND_BITS(CND_BITS),
      .OUT_BITS(OUT_BITS)
    ) u_lane (
      .cond (cond_v[p]),
      .word (word_v[p]),
      .addr (addr_v[p]),
      .state(st_v[p]),
      .outs (out_v[p])
    );
  end

  rom_fsm_table #(
    .ST_BITS (ST_BITS),
    .CND_BITS(CND_BITS),
    .OUT_BITS(OUT_BITS),
    .NPORTS  (NP),
    .AW      (AW),
    .DW      (DW),
    .RST_WORD(RST_WORD)
  ) u_table (
    .clk  (clk_v),
    .rst  (rst_v),
    .addr (addr_v),
    .rdata(word_v)
  );

  assign state_a = st_v[0];
  assign out_a   = out_v[0];
  assign state_b = st_v[1];
  assign out_b   = out_v[1];

endmodule

// File: rtl/rom_fsm_dual_chk.sv
module rom_fsm_dual_chk #(
  parameter int ST_BITS  = 3,
  parameter int CND_BITS = 2,
  parameter int OUT_BITS = 3,
  parameter logic [OUT_BITS-1:0] RST_OUT = 3'b100
) (
  input logic                clk_a,
  input logic                rst_a,
  input logic [CND_BITS-1:0] cond_a,
  input logic [ST_BITS-1:0]  state_a,
  input logic [OUT_BITS-1:0] out_a,
  input logic                clk_b,
  input logic                rst_b,
  input logic [CND_BITS-1:0] cond_b,
  input logic [ST_BITS-1:0]  state_b,
  input logic [OUT_BITS-1:0] out_b
);

  localparam int LEGAL = (1 << ST_BITS) - 2;
  localparam logic [ST_BITS-1:0] TOP = ST_BITS'(LEGAL - 1);
  localparam logic [ST_BITS-1:0] LIM = ST_BITS'(LEGAL);

  // Port A
  assert_reset_a_R1: assert property (@(posedge clk_a)
    rst_a |=> (state_a == '0 && out_a == RST_OUT));
  assert_clear_a_R2: assert property (@(posedge clk_a) disable iff (rst_a)
    cond_a[1] |=> (state_a == '0 && out_a[1] && !out_a[2]));
  assert_legal_a_R3: assert property (@(posedge clk_a) disable iff (rst_a)
    state_a < LIM);
  assert_hold_a_R4: assert property (@(posedge clk_a) disable iff (rst_a)
    cond_a[1:0] == 2'b00 |=> $stable(state_a));
  assert_top_a_R5: assert property (@(posedge clk_a) disable iff (rst_a)
    out_a[0] == (state_a == TOP));
  assert_step_a_R6: assert property (@(posedge clk_a) disable iff (rst_a)
    cond_a[1:0] == 2'b01 |=> out_a[2]);

  // Port B
  assert_reset_b_R1: assert property (@(posedge clk_b)
    rst_b |=> (state_b == '0 && out_b == RST_OUT));
  assert_clear_b_R2: assert property (@(posedge clk_b) disable iff (rst_b)
    cond_b[1] |=> (state_b == '0 && out_b[1] && !out_b[2]));
  assert_legal_b_R3: assert property (@(posedge clk_b) disable iff (rst_b)
    state_b < LIM);
  assert_hold_b_R4: assert property (@(posedge clk_b) disable iff (rst_b)
    cond_b[1:0] == 2'b00 |=> $stable(state_b));
  assert_top_b_R5: assert property (@(posedge clk_b) disable iff (rst_b)
    out_b[0] == (state_b == TOP));
  assert_step_b_R6: assert property (@(posedge clk_b) disable iff (rst_b)
    cond_b[1:0] == 2'b01 |=> out_b[2]);

endmodule

bind rom_fsm_dual rom_fsm_dual_chk #(
  .ST_BITS (ST_BITS),
  .CND_BITS(CND_BITS),
  .OUT_BITS(OUT_BITS),
  .RST_OUT (RST_OUT)
) i_chk (.*);

// File: tb/test_rom_fsm_dual.sv
module test_rom_fsm_dual;

  localparam int RST_OUT = 4;
  localparam int TOPST   = 5;

  logic       clk_a = 1'b0;
  logic       clk_b = 1'b0;
  logic       rst_a = 1'b1;
  logic       rst_b = 1'b1;
  logic [1:0] cond_a = 2'b00;
  logic [1:0] cond_b = 2'b00;
  logic [2:0] state_a, state_b, out_a, out_b;

  always #2 clk_a = ~clk_a;   // 250 MHz
  always #3 clk_b = ~clk_b;   // unrelated second clock

  rom_fsm_dual i_rom_fsm_dual (
    .clk_a(clk_a), .rst_a(rst_a), .cond_a(cond_a), .state_a(state_a), .out_a(out_a),
    .clk_b(clk_b), .rst_b(rst_b), .cond_b(cond_b), .state_b(state_b), .out_b(out_b)
  );

  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done_a = 0;
  bit    done_b = 0;

  int    ms_a = 0, mo_a = RST_OUT, ms_b = 0, mo_b = RST_OUT;
  string tag_a = "R1", tag_b = "R1";

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Behavioural counter: legal states 0..5, step wraps, clear wins.
  task automatic model(input bit rst, input logic [1:0] c, inout int st, inout int o,
                       output string tag);
    bit clr, stp;
    if (rst) begin
      st = 0; o = RST_OUT; tag = "R1";
    end else begin
      clr = c[1];
      stp = c[0] && !c[1];
      if (clr)      st = 0;
      else if (stp) st = (st == TOPST) ? 0 : st + 1;
      o   = (stp ? 4 : 0) + (st == 0 ? 2 : 0) + (st == TOPST ? 1 : 0);
      tag = clr ? "R2" : (stp ? "R3" : "R4");
    end
  endtask

  always @(posedge clk_a) begin
    model(rst_a, cond_a, ms_a, mo_a, tag_a);
    if (!rst_a && rst_b) tag_a = "R8";
  end

  always @(posedge clk_b) begin
    model(rst_b, cond_b, ms_b, mo_b, tag_b);
    if (!rst_b && rst_a) tag_b = "R8";
  end

  function automatic logic [1:0] pick();
    int r = $urandom_range(0, 7);
    if (r == 0)      return ($urandom_range(0, 1) != 0) ? 2'b11 : 2'b10;
    else if (r < 5)  return 2'b01;
    else             return 2'b00;
  endfunction

  initial begin
    for (int i = 0; i < 600; i++) begin
      @(negedge clk_a);
      if (i > 0) begin
        chk(tag_a, "A state", int'(state_a), ms_a);
        chk("R7", "A outputs", int'(out_a), mo_a);
        chk("R5", "A top flag", int'(out_a[0]), mo_a % 2);
        chk("R6", "A stepped flag", int'(out_a[2]), mo_a / 4);
      end
      rst_a  = (i < 3) || (i >= 400 && i < 404);
      cond_a = (i >= 10 && i < 20) ? 2'b01 : pick();
    end
    done_a = 1;
  end

  initial begin
    for (int i = 0; i < 400; i++) begin
      @(negedge clk_b);
      if (i > 0) begin
        chk(tag_b, "B state", int'(state_b), ms_b);
        chk("R7", "B outputs", int'(out_b), mo_b);
        chk("R5", "B top flag", int'(out_b[0]), mo_b % 2);
        chk("R6", "B stepped flag", int'(out_b[2]), mo_b / 4);
      end
      rst_b  = (i < 2) || (i >= 150 && i < 156);
      cond_b = (i >= 30 && i < 45) ? 2'b00 : pick();
    end
    done_b = 1;
  end

  initial begin
    #100000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired before both ports finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (done_a && done_b);
    #1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule